// File: doc/BRIEF.md
# Read-Sequence Nonvolatile Command Detector

This block sits beside a 2048-byte static RAM and watches its external access pins. Software asks for a nonvolatile save (STORE) or restore (RECALL) by issuing six reads in a row to a fixed set of addresses, using ordinary read cycles only. The detector counts these reads and compares each one with the expected address. When the sixth read completes a valid sequence, it sends a one-cycle request to the nonvolatile cycle controller. It also raises a flag that holds the data outputs in high impedance for the rest of that final access.

Each access is marked by chip enable falling while write enable is high. Chip enable comes from the pins without a clock, so it first passes through a synchroniser chain of `SYNC_STAGES` flops. One further flop holds the previous synchronised value, and the falling edge is found by comparing the two. In the cycle the edge is seen, the address and write enable are captured.

The matcher is a state machine with these states:
- `ST_IDLE`: nothing matched.
- `ST_M1` to `ST_M5`: one to five prefix addresses matched.

It takes these transitions on each captured access:
- *advance*: the address equals the next expected prefix address, so the step goes up by one.
- *restart*: the address is a mismatch but equals the first prefix address, so the machine goes to `ST_M1`.
- *abort*: any other mismatch, or any write, returns the machine to `ST_IDLE`.
- *issue*: in `ST_M5`, a STORE or RECALL address fires the request and returns to `ST_IDLE`.
- *clear*: the controller's busy input forces `ST_IDLE` in every state.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: After reset, `match_step` is 0, and `store_req`, `recall_req` and `out_hiz` are low.
- R2: Six reads form a STORE command when their addresses are 000, 555, 2AA, 7FF, 0F0 and 70F (hex), in that order, and `pwr_ok` is high. For that command `store_req` is high for exactly one clock. The pulse appears `SYNC_STAGES`+2 clock edges after the edge on which chip enable is first driven low for the sixth read.
- R3: The same five-address prefix followed by 70E produces exactly one one-clock `recall_req` pulse and no `store_req`.
- R4: The prefix followed by 39C produces neither request, leaves `out_hiz` low and returns `match_step` to 0.
- R5: An access made with `we_n` low at any point in the sequence aborts it: `match_step` returns to 0 and the rest of the sequence issues no request.
- R6: A read that does not match the expected address aborts the sequence (`match_step` 0). The exception is a mismatching read to 000, which sets `match_step` to 1.
- R7: Each chip-enable assertion counts once, however long it lasts. Two consecutive reads of the same non-initial address abort the sequence.
- R8: With `pwr_ok` low, a complete STORE sequence issues no `store_req` and leaves `out_hiz` low. A complete RECALL sequence still issues `recall_req`.
- R9: `out_hiz` rises on the same clock as the request pulse. It stays high while chip enable is held low, and it falls `SYNC_STAGES`+1 clock edges after chip enable is driven high.
- R10: While `ctrl_busy` is high, `match_step` is held at 0 and reads are ignored.
- R11: A chip-enable low pulse that lasts only two clock periods counts toward the sequence.
- R12: `match_step` gives the number of prefix addresses matched so far, from 0 to 5, and never skips a value when it advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Memory address pins |
| ce_n | input | 1 | Chip enable, active low, asynchronous to clk |
| we_n | input | 1 | Write enable, active low |
| pwr_ok | input | 1 | Supply above the store threshold |
| ctrl_busy | input | 1 | Nonvolatile controller is running a cycle |
| store_req | output | 1 | One-cycle STORE request |
| recall_req | output | 1 | One-cycle RECALL request |
| out_hiz | output | 1 | Hold the data outputs in high impedance for the final access |
| match_step | output | 3 | Count of prefix addresses matched (0 to 5) |

## Verification
The bench builds the block with `ADDR_W` = 11 and `SYNC_STAGES` = 3, not the default of 2. This moves the request latency to five edges and the release of `out_hiz` to four edges. A check that counts cycles therefore catches a latency hard-coded to the default depth. The three-stage chain still has to pass a two-cycle chip-enable pulse, and that is the shortest pulse R11 allows.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_M1   = 3'd1,
        ST_M2   = 3'd2,
        ST_M3   = 3'd3,
        ST_M4   = 3'd4,
        ST_M5   = 3'd5
    } seq_state_e;

    localparam int PREFIX_LEN = 5;
    localparam int BASE_AW    = 11;

    localparam logic [BASE_AW-1:0] CMD_STORE  = 11'h70F;
    localparam logic [BASE_AW-1:0] CMD_RECALL = 11'h70E;

    // Expected address of the prefix read with index idx (0 = first).
    function automatic logic [BASE_AW-1:0] prefix_addr(input int idx);
        logic [BASE_AW-1:0] a;
        case (idx)
            0:       a = 11'h000;
            1:       a = 11'h555;
            2:       a = 11'h2AA;
            3:       a = 11'h7FF;
            4:       a = 11'h0F0;
            default: a = 11'h000;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/nvcmd_ce_front.sv
module nvcmd_ce_front #(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              acc_vld_o,
    output logic              acc_rd_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              ce_high_o
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   fall;

    // Synchroniser chain: stage 0 samples the pin, each later stage follows the one before.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[s] <= 1'b1;
                    else        sync_q[s] <= ce_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[s] <= 1'b1;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[TOP];
    end

    assign fall = prev_q & ~sync_q[TOP];

    // Capture the access on the detected falling edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_vld_o  <= 1'b0;
            acc_rd_o   <= 1'b0;
            acc_addr_o <= '0;
        end else begin
            acc_vld_o <= fall;
            if (fall) begin
                acc_rd_o   <= we_n_i;
                acc_addr_o <= addr_i;
            end
        end
    end

    assign ce_high_o = sync_q[TOP];

endmodule

// File: rtl/nvcmd_addr_match.sv
module nvcmd_addr_match
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  seq_state_e        step_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              adv_o,
    output logic              restart_o,
    output logic              store_hit_o,
    output logic              recall_hit_o
);

    logic [PREFIX_LEN-1:0] pre_hit;

    // One comparator for each prefix position.
    generate
        for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_cmp
            assign pre_hit[g] = (addr_i == ADDR_W'(prefix_addr(g)));
        end
    endgenerate

    always_comb begin
        adv_o = 1'b0;
        unique case (step_i)
            ST_IDLE: adv_o = pre_hit[0];
            ST_M1:   adv_o = pre_hit[1];
            ST_M2:   adv_o = pre_hit[2];
            ST_M3:   adv_o = pre_hit[3];
            ST_M4:   adv_o = pre_hit[4];
            ST_M5:   adv_o = 1'b0;
            default: adv_o = 1'b0;
        endcase
    end

    assign restart_o    = pre_hit[0];
    assign store_hit_o  = (addr_i == ADDR_W'(CMD_STORE));
    assign recall_hit_o = (addr_i == ADDR_W'(CMD_RECALL));

endmodule

// File: rtl/nvcmd_seq_fsm.sv
module nvcmd_seq_fsm
    import nvcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_vld_i,
    input  logic       acc_rd_i,
    input  logic       adv_i,
    input  logic       restart_i,
    input  logic       store_hit_i,
    input  logic       recall_hit_i,
    input  logic       pwr_ok_i,
    input  logic       busy_i,
    input  logic       ce_high_i,
    output seq_state_e state_o,
    output logic       store_req_o,
    output logic       recall_req_o,
    output logic       out_hiz_o
);

    seq_state_e state_q, state_d;
    logic       issue_store, issue_recall;
    seq_state_e miss_state;

    assign miss_state = restart_i ? ST_M1 : ST_IDLE;

    always_comb begin
        state_d      = state_q;
        issue_store  = 1'b0;
        issue_recall = 1'b0;
        if (busy_i) begin
            state_d = ST_IDLE;                       // clear
        end else if (acc_vld_i) begin
            if (!acc_rd_i) begin
                state_d = ST_IDLE;                   // abort on write
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = adv_i ? ST_M1 : ST_IDLE;
                    ST_M1:   state_d = adv_i ? ST_M2 : miss_state;
                    ST_M2:   state_d = adv_i ? ST_M3 : miss_state;
                    ST_M3:   state_d = adv_i ? ST_M4 : miss_state;
                    ST_M4:   state_d = adv_i ? ST_M5 : miss_state;
                    ST_M5: begin
                        if (store_hit_i) begin
                            issue_store = pwr_ok_i;  // issue, inhibited on low supply
                            state_d     = ST_IDLE;
                        end else if (recall_hit_i) begin
                            issue_recall = 1'b1;     // issue
                            state_d      = ST_IDLE;
                        end else begin
                            state_d = miss_state;
                        end
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_req_o  <= 1'b0;
            recall_req_o <= 1'b0;
            out_hiz_o    <= 1'b0;
        end else begin
            store_req_o  <= issue_store;
            recall_req_o <= issue_recall;
            if (issue_store || issue_recall) out_hiz_o <= 1'b1;
            else if (ce_high_i)              out_hiz_o <= 1'b0;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              pwr_ok,
    input  logic              ctrl_busy,
    output logic              store_req,
    output logic              recall_req,
    output logic              out_hiz,
    output logic [2:0]        match_step
);

    logic              acc_vld, acc_rd, ce_high;
    logic [ADDR_W-1:0] acc_addr;
    logic              adv, restart, store_hit, recall_hit;
    seq_state_e        state;

    nvcmd_ce_front #(
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n_i     (ce_n),
        .we_n_i     (we_n),
        .addr_i     (addr),
        .acc_vld_o  (acc_vld),
        .acc_rd_o   (acc_rd),
        .acc_addr_o (acc_addr),
        .ce_high_o  (ce_high)
    );

    nvcmd_addr_match #(
        .ADDR_W (ADDR_W)
    ) u_match (
        .step_i       (state),
        .addr_i       (acc_addr),
        .adv_o        (adv),
        .restart_o    (restart),
        .store_hit_o  (store_hit),
        .recall_hit_o (recall_hit)
    );

    nvcmd_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_vld_i    (acc_vld),
        .acc_rd_i     (acc_rd),
        .adv_i        (adv),
        .restart_i    (restart),
        .store_hit_i  (store_hit),
        .recall_hit_i (recall_hit),
        .pwr_ok_i     (pwr_ok),
        .busy_i       (ctrl_busy),
        .ce_high_i    (ce_high),
        .state_o      (state),
        .store_req_o  (store_req),
        .recall_req_o (recall_req),
        .out_hiz_o    (out_hiz)
    );

    assign match_step = 3'(state);

endmodule

// File: rtl/nvcmd_seq_detect_chk.sv
module nvcmd_seq_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_ok,
    input logic       ctrl_busy,
    input logic       store_req,
    input logic       recall_req,
    input logic       out_hiz,
    input logic [2:0] match_step
);

    // R2 R3: the two requests never coincide
    a_r3_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));

    // R2: store pulse lasts one clock
    a_r2_store_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    // R3: recall pulse lasts one clock
    a_r3_recall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);

    // R2: a store is only issued from the fifth matched step
    a_r2_store_from_m5: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> $past(match_step) == 3'd5);

    // R8: a store needs the supply to be good
    a_r8_store_power: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> $past(pwr_ok));

    // R9: out_hiz only rises together with a request
    a_r9_hiz_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_hiz) |-> (store_req || recall_req));

    // R10: busy clears the match
    a_r10_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_busy |=> match_step == 3'd0);

    // R12: step stays in range and advances by at most one
    a_r12_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        match_step <= 3'd5);

    a_r12_step_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (match_step != $past(match_step)) |->
        (match_step == 3'd0 || match_step == 3'd1 || match_step == $past(match_step) + 3'd1));

endmodule

bind nvcmd_seq_detect nvcmd_seq_detect_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_ok     (pwr_ok),
    .ctrl_busy  (ctrl_busy),
    .store_req  (store_req),
    .recall_req (recall_req),
    .out_hiz    (out_hiz),
    .match_step (match_step)
);

// File: tb/test_nvcmd_seq_detect.sv
`timescale 1ns/1ps
module test_nvcmd_seq_detect;

    localparam int AW   = 11;
    localparam int SYNC = 3;
    localparam int LAT  = SYNC + 2;
    localparam int GAP  = SYNC + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          pwr_ok = 1'b1;
    logic          ctrl_busy = 1'b0;
    logic          store_req, recall_req, out_hiz;
    logic [2:0]    match_step;

    int n_chk = 0;
    int n_fail = 0;
    int store_cnt = 0;
    int recall_cnt = 0;
    int hiz_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nvcmd_seq_detect #(.ADDR_W(AW), .SYNC_STAGES(SYNC)) i_nvcmd_seq_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .pwr_ok     (pwr_ok),
        .ctrl_busy  (ctrl_busy),
        .store_req  (store_req),
        .recall_req (recall_req),
        .out_hiz    (out_hiz),
        .match_step (match_step)
    );

    always @(negedge clk) begin
        if (store_req)  store_cnt++;
        if (recall_req) recall_cnt++;
        if (out_hiz)    hiz_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input bit wr, input int low);
        @(negedge clk);
        addr = a; we_n = ~wr; ce_n = 1'b0;
        repeat (low) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic prefix(input int low);
        access(11'h000, 0, low);
        access(11'h555, 0, low);
        access(11'h2AA, 0, low);
        access(11'h7FF, 0, low);
        access(11'h0F0, 0, low);
    endtask

    task automatic t_reset;
        chk("R1 step", match_step, 0);
        chk("R1 store_req", store_req, 0);
        chk("R1 recall_req", recall_req, 0);
        chk("R1 out_hiz", out_hiz, 0);
    endtask

    task automatic t_store_timing;
        int s0;
        s0 = store_cnt;
        prefix(4);
        chk("R12 step after prefix", match_step, 5);
        @(negedge clk);
        addr = 11'h70F; ce_n = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        chk("R2 no early store", store_req, 0);
        @(negedge clk);
        chk("R2 store at latency", store_req, 1);
        chk("R9 hiz with request", out_hiz, 1);
        @(negedge clk);
        chk("R2 store one cycle", store_req, 0);
        chk("R9 hiz held while ce low", out_hiz, 1);
        ce_n = 1'b1;
        repeat (SYNC) @(negedge clk);
        chk("R9 hiz still high", out_hiz, 1);
        @(negedge clk);
        chk("R9 hiz released", out_hiz, 0);
        repeat (GAP) @(negedge clk);
        chk("R2 store count", store_cnt - s0, 1);
        chk("R2 step back to idle", match_step, 0);
    endtask

    task automatic t_recall;
        int s0, r0;
        s0 = store_cnt; r0 = recall_cnt;
        prefix(4);
        access(11'h70E, 0, 4);
        chk("R3 recall count", recall_cnt - r0, 1);
        chk("R3 no store", store_cnt - s0, 0);
    endtask

    task automatic t_test_addr;
        int s0, r0, h0;
        s0 = store_cnt; r0 = recall_cnt; h0 = hiz_cnt;
        prefix(4);
        access(11'h39C, 0, 4);
        chk("R4 no store", store_cnt - s0, 0);
        chk("R4 no recall", recall_cnt - r0, 0);
        chk("R4 no hiz", hiz_cnt - h0, 0);
        chk("R4 step idle", match_step, 0);
    endtask

    task automatic t_write_abort;
        int s0;
        s0 = store_cnt;
        access(11'h000, 0, 4);
        access(11'h555, 0, 4);
        chk("R5 step before write", match_step, 2);
        access(11'h2AA, 1, 4);
        chk("R5 step after write", match_step, 0);
        access(11'h2AA, 0, 4);
        access(11'h7FF, 0, 4);
        access(11'h0F0, 0, 4);
        access(11'h70F, 0, 4);
        chk("R5 no store after write", store_cnt - s0, 0);
    endtask

    task automatic t_restart;
        int s0;
        s0 = store_cnt;
        access(11'h000, 0, 4);
        access(11'h555, 0, 4);
        access(11'h2AA, 0, 4);
        access(11'h123, 0, 4);
        chk("R6 mismatch aborts", match_step, 0);
        access(11'h000, 0, 4);
        access(11'h555, 0, 4);
        access(11'h000, 0, 4);
        chk("R6 mismatch at 000 restarts", match_step, 1);
        access(11'h555, 0, 4);
        access(11'h2AA, 0, 4);
        chk("R12 step three", match_step, 3);
        access(11'h7FF, 0, 4);
        access(11'h0F0, 0, 4);
        access(11'h70F, 0, 4);
        chk("R6 store after restart", store_cnt - s0, 1);
    endtask

    task automatic t_once;
        access(11'h000, 0, 20);
        chk("R7 long pulse counted once", match_step, 1);
        access(11'h555, 0, 4);
        access(11'h555, 0, 4);
        chk("R7 repeated address aborts", match_step, 0);
    endtask

    task automatic t_power;
        int s0, r0, h0;
        pwr_ok = 1'b0;
        s0 = store_cnt; h0 = hiz_cnt;
        prefix(4);
        access(11'h70F, 0, 4);
        chk("R8 store inhibited", store_cnt - s0, 0);
        chk("R8 no hiz when inhibited", hiz_cnt - h0, 0);
        r0 = recall_cnt;
        prefix(4);
        access(11'h70E, 0, 4);
        chk("R8 recall not inhibited", recall_cnt - r0, 1);
        pwr_ok = 1'b1;
    endtask

    task automatic t_busy;
        access(11'h000, 0, 4);
        access(11'h555, 0, 4);
        @(negedge clk); ctrl_busy = 1'b1;
        @(negedge clk); ctrl_busy = 1'b0;
        chk("R10 busy clears step", match_step, 0);
        ctrl_busy = 1'b1;
        access(11'h000, 0, 4);
        chk("R10 read ignored while busy", match_step, 0);
        ctrl_busy = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_short;
        int r0;
        r0 = recall_cnt;
        prefix(2);
        chk("R11 short pulses matched", match_step, 5);
        access(11'h70E, 0, 2);
        chk("R11 recall on short pulses", recall_cnt - r0, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_store_timing();
        t_recall();
        t_test_addr();
        t_write_abort();
        t_restart();
        t_once();
        t_power();
        t_busy();
        t_short();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
        $finish;
    end

endmodule